// File: doc/BRIEF.md
# Strided Block Address Generator

This block generates the byte address and beat size for one side of a DMA transfer, either source or destination. A start pulse captures a base address, a packed 32-bit control word, a stride-enable flag and a total byte count. The block then presents one beat at a time. Each beat that the consumer accepts with `ready_i` moves the address on. The run ends on the beat that exhausts the byte count.

The address can move in four ways: increment, decrement, hold, or a wrapping burst confined to an aligned group of beats. When striding is enabled and the block size is non-zero, the address jumps after each block of bytes. The new address is the start of that block plus the stride, whatever the movement mode. The block does not move data, drive a bus protocol or parse descriptors.

Top module: `stride_agen`

## Requirements
- R1: The control word is decoded as follows. Bits 31:30 give the beat size code: 0 is 1 byte, 1 is 2 bytes, 2 is 4 bytes and 3 is 8 bytes. `size_o` reports this code for every beat of the run.
- R2: A start pulse while idle loads the configuration. From the next cycle `valid_o` is high and `addr_o` equals the base address. A start pulse while a run is active is ignored.
- R3: With movement code 0 (bits 29:28), each accepted beat raises the address by the beat size in bytes.
- R4: With movement code 1, each accepted beat lowers the address by the beat size. The address wraps modulo 2^AW.
- R5: With movement code 2, the address holds for the whole run.
- R6: With movement code 3, the address increments by the beat size but wraps within an aligned group of BURST_BEATS beats. The group is the one that holds the base address.
- R7: Striding applies when `stride_en_i` is high and the block size (bits 27:14, in bytes) is non-zero. Once the accepted bytes of the current block reach the block size, the next address is the block start plus the stride (bits 13:0). That address becomes the new block start and the block byte count restarts.
- R8: With `stride_en_i` low, or with a block size of zero, the address follows only the movement mode.
- R9: Each accepted beat lowers the remaining byte count by the beat size. `last_o` is high while the remaining count is at most one beat. Accepting that beat ends the run.
- R10: While `ready_i` is low, the address and last flag hold and the run stays active.
- R11: `done_o` pulses for one cycle, in the cycle after the last beat is accepted. A start with a total of zero produces no beats and pulses `done_o` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Load configuration and begin a run (idle only) |
| base_i | input | AW | Starting byte address |
| ctrl_i | input | 32 | Packed size, movement, block size and stride |
| stride_en_i | input | 1 | Enable block striding for this run |
| total_i | input | CW | Total bytes to transfer |
| ready_i | input | 1 | Consumer accepts the current beat |
| valid_o | output | 1 | A beat is presented |
| addr_o | output | AW | Byte address of the current beat |
| size_o | output | 2 | Beat size code of the current beat |
| last_o | output | 1 | Current beat is the final one |
| done_o | output | 1 | One-cycle pulse after the run ends |

## Verification
The bench builds the block with AW=16, CW=12 and the default BURST_BEATS=4. With a 16-bit address, a decrement run crosses zero within a few beats. The same width lets stride jumps near the top of the space truncate, so both wrap paths are exercised with short runs. The 12-bit count keeps runs short enough to cover:
- every movement mode;
- every beat size;
- strided and plain runs;
- stalled handshakes;
- counts that are not a multiple of the beat size.

// File: rtl/stride_agen_pkg.sv
package stride_agen_pkg;

  localparam int unsigned FIELD_W = 14;

  typedef enum logic [1:0] {
    MV_INC  = 2'd0,
    MV_DEC  = 2'd1,
    MV_HOLD = 2'd2,
    MV_WRAP = 2'd3
  } move_e;

  // layout of the 32-bit control word, msb first
  typedef struct packed {
    logic [1:0]         size;
    move_e              move;
    logic [FIELD_W-1:0] blk;
    logic [FIELD_W-1:0] stride;
  } side_ctrl_t;

  function automatic logic [3:0] beat_bytes(input logic [1:0] code);
    return 4'd1 << code;
  endfunction

endpackage

// File: rtl/stride_agen_step.sv
module stride_agen_step
  import stride_agen_pkg::*;
#(
  parameter int unsigned AW          = 32,
  parameter int unsigned BURST_BEATS = 4
) (
  input  logic [AW-1:0] addr_i,
  input  logic [1:0]    size_i,
  input  move_e         move_i,
  output logic [AW-1:0] next_o
);

  localparam int unsigned GRP_SHIFT = $clog2(BURST_BEATS);

  logic [AW-1:0] step;
  logic [AW-1:0] inc;
  logic [AW-1:0] wrap;

  assign step = AW'(beat_bytes(size_i));
  assign inc  = addr_i + step;

  generate
    if (GRP_SHIFT == 0) begin : g_no_group
      assign wrap = addr_i;
    end else begin : g_group
      logic [AW-1:0] grp_mask;
      assign grp_mask = (step << GRP_SHIFT) - AW'(1);
      assign wrap     = (addr_i & ~grp_mask) | (inc & grp_mask);
    end
  endgenerate

  always_comb begin
    unique case (move_i)
      MV_INC:  next_o = inc;
      MV_DEC:  next_o = addr_i - step;
      MV_HOLD: next_o = addr_i;
      default: next_o = wrap;
    endcase
  end

endmodule

// File: rtl/stride_agen_block.sv
module stride_agen_block
  import stride_agen_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [AW-1:0]      base_i,
  input  logic               adv_i,
  input  logic [3:0]         bytes_i,
  input  logic               en_i,
  input  logic [FIELD_W-1:0] blk_i,
  input  logic [FIELD_W-1:0] stride_i,
  input  logic [AW-1:0]      lin_next_i,
  output logic [AW-1:0]      next_o
);

  logic [AW-1:0]    start_q;
  logic [FIELD_W:0] cnt_q;
  logic [FIELD_W:0] cnt_sum;
  logic             active;
  logic             jump;

  assign active  = en_i && (blk_i != '0);
  assign cnt_sum = cnt_q + (FIELD_W+1)'(bytes_i);
  assign jump    = active && (cnt_sum >= {1'b0, blk_i});
  assign next_o  = jump ? start_q + AW'(stride_i) : lin_next_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q <= '0;
      cnt_q   <= '0;
    end else if (load_i) begin
      start_q <= base_i;
      cnt_q   <= '0;
    end else if (adv_i && active) begin
      if (jump) begin
        start_q <= next_o;
        cnt_q   <= '0;
      end else begin
        cnt_q <= cnt_sum;
      end
    end
  end

  // R7: byte count inside a block never reaches the block size
  a_r7_cnt_in_block: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active |-> (cnt_q < {1'b0, blk_i}));

  // R7: a jump restarts the block from the address it jumped to
  a_r7_jump_restarts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && jump && !load_i) |=> (cnt_q == '0) && (start_q == $past(next_o)));

endmodule

// File: rtl/stride_agen_count.sv
module stride_agen_count #(
  parameter int unsigned CW = 22
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] total_i,
  input  logic          adv_i,
  input  logic [3:0]    bytes_i,
  output logic          last_o
);

  logic [CW-1:0] rem_q;

  assign last_o = rem_q <= CW'(bytes_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q <= '0;
    end else if (load_i) begin
      rem_q <= total_i;
    end else if (adv_i) begin
      rem_q <= last_o ? '0 : rem_q - CW'(bytes_i);
    end
  end

  // R9: every accepted non-final beat shrinks the remaining count
  a_r9_rem_shrinks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !last_o && !load_i) |=> (rem_q < $past(rem_q)));

endmodule

// File: rtl/stride_agen.sv
module stride_agen
  import stride_agen_pkg::*;
#(
  parameter int unsigned AW          = 32,
  parameter int unsigned CW          = 22,
  parameter int unsigned BURST_BEATS = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [AW-1:0] base_i,
  input  logic [31:0]   ctrl_i,
  input  logic          stride_en_i,
  input  logic [CW-1:0] total_i,
  input  logic          ready_i,
  output logic          valid_o,
  output logic [AW-1:0] addr_o,
  output logic [1:0]    size_o,
  output logic          last_o,
  output logic          done_o
);

  side_ctrl_t    cfg_q;
  logic          sen_q;
  logic          busy_q;
  logic          done_q;
  logic [AW-1:0] addr_q;
  logic [AW-1:0] lin_next;
  logic [AW-1:0] next_addr;
  logic [3:0]    bytes;
  logic          load;
  logic          adv;
  logic          cnt_last;

  assign load  = start_i && !busy_q;
  assign adv   = busy_q && ready_i;
  assign bytes = beat_bytes(cfg_q.size);

  stride_agen_step #(.AW(AW), .BURST_BEATS(BURST_BEATS)) u_step (
    .addr_i (addr_q),
    .size_i (cfg_q.size),
    .move_i (cfg_q.move),
    .next_o (lin_next)
  );

  stride_agen_block #(.AW(AW)) u_block (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .base_i     (base_i),
    .adv_i      (adv),
    .bytes_i    (bytes),
    .en_i       (sen_q),
    .blk_i      (cfg_q.blk),
    .stride_i   (cfg_q.stride),
    .lin_next_i (lin_next),
    .next_o     (next_addr)
  );

  stride_agen_count #(.CW(CW)) u_count (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .total_i (total_i),
    .adv_i   (adv),
    .bytes_i (bytes),
    .last_o  (cnt_last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q  <= side_ctrl_t'(32'd0);
      sen_q  <= 1'b0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      addr_q <= '0;
    end else if (load) begin
      cfg_q  <= side_ctrl_t'(ctrl_i);
      sen_q  <= stride_en_i;
      addr_q <= base_i;
      busy_q <= (total_i != '0);
      done_q <= (total_i == '0);
    end else begin
      done_q <= adv && cnt_last;
      if (adv) begin
        addr_q <= next_addr;
        if (cnt_last) busy_q <= 1'b0;
      end
    end
  end

  assign valid_o = busy_q;
  assign addr_o  = addr_q;
  assign size_o  = cfg_q.size;
  assign last_o  = busy_q && cnt_last;
  assign done_o  = done_q;

  a_r9_last_needs_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |-> valid_o);

  a_r10_hold_on_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !ready_i) |=> valid_o && $stable(addr_o) && $stable(last_o));

  a_r2_run_persists: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !(ready_i && last_o)) |=> valid_o);

  a_r5_hold_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && ready_i && !last_o && !sen_q && cfg_q.move == MV_HOLD)
      |=> addr_o == $past(addr_o));

  a_r4_dec_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && ready_i && !last_o && !sen_q && cfg_q.move == MV_DEC)
      |=> addr_o == $past(addr_o) - AW'($past(bytes)));

  a_r11_done_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !valid_o);

endmodule

// File: tb/stride_agen_tb_top.sv
`timescale 1ns/1ps
module stride_agen_tb_top;

  localparam int AW = 16;
  localparam int CW = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [AW-1:0] base = '0;
  logic [31:0]   ctrl = '0;
  logic          sen = 1'b0;
  logic [CW-1:0] total = '0;
  logic          ready = 1'b0;
  logic          valid, last, done;
  logic [AW-1:0] addr;
  logic [1:0]    size;

  int    checks = 0;
  int    errors = 0;
  bit    finished = 0;
  string cur_req = "R1";

  // behavioural reference state
  bit        m_busy = 0, m_done = 0, m_sen = 0;
  int        m_ts = 0, m_mv = 0, m_blk = 0, m_str = 0, m_rem = 0, m_cnt = 0;
  logic [15:0] m_addr = '0, m_bs = '0;
  logic [15:0] seen[$];

  always #10 clk = ~clk;

  stride_agen #(.AW(AW), .CW(CW), .BURST_BEATS(4)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .base_i(base), .ctrl_i(ctrl),
    .stride_en_i(sen), .total_i(total), .ready_i(ready), .valid_o(valid),
    .addr_o(addr), .size_o(size), .last_o(last), .done_o(done)
  );

  function automatic logic [31:0] mk_ctrl(int ts, int mv, int blk, int str);
    return {2'(ts), 2'(mv), 14'(blk), 14'(str)};
  endfunction

  task automatic compare();
    bit bad;
    bit exp_last;
    exp_last = m_busy && (m_rem <= (1 << m_ts));
    bad = (valid !== m_busy) || (done !== m_done);
    if (m_busy) bad = bad || (addr !== m_addr) || (size !== 2'(m_ts)) || (last !== exp_last);
    checks++;
    if (bad) begin
      errors++;
      $display("FAIL %s: valid=%0b addr=%h size=%0d last=%0b done=%0b expected valid=%0b addr=%h size=%0d last=%0b done=%0b",
               cur_req, valid, addr, size, last, done, m_busy, m_addr, m_ts, exp_last, m_done);
    end
  endtask

  task automatic model_step(bit st, bit rdy);
    int  b;
    bit  jumped;
    int  g, off;
    b = 1 << m_ts;
    m_done = 0;
    if (!m_busy && st) begin
      m_ts = int'(ctrl[31:30]); m_mv = int'(ctrl[29:28]);
      m_blk = int'(ctrl[27:14]); m_str = int'(ctrl[13:0]);
      m_sen = sen; m_addr = base; m_bs = base; m_cnt = 0; m_rem = int'(total);
      if (total == 0) m_done = 1; else m_busy = 1;
    end else if (m_busy && rdy) begin
      if (m_rem <= b) begin m_busy = 0; m_done = 1; end
      else m_rem -= b;
      jumped = 0;
      if (m_sen && m_blk != 0) begin
        m_cnt += b;
        if (m_cnt >= m_blk) begin
          m_addr = 16'(int'(m_bs) + m_str);
          m_bs = m_addr; m_cnt = 0; jumped = 1;
        end
      end
      if (!jumped) begin
        case (m_mv)
          0: m_addr = 16'(int'(m_addr) + b);
          1: m_addr = 16'(int'(m_addr) - b);
          2: ;
          default: begin
            g = 4 * b; off = int'(m_addr) % g;
            m_addr = 16'(int'(m_addr) - off + ((off + b) % g));
          end
        endcase
      end
    end
  endtask

  task automatic tick(bit st, bit rdy);
    @(negedge clk);
    start = st; ready = rdy;
    #1;
    compare();
    if (valid && rdy) seen.push_back(addr);
    model_step(st, rdy);
  endtask

  // stall_mod > 0: ready is low every stall_mod-th cycle; restart_at > 0: extra start mid-run
  task automatic run(string req, logic [15:0] b0, logic [31:0] c, bit s, int tot,
                     int stall_mod, int restart_at);
    int n;
    cur_req = req;
    base = b0; ctrl = c; sen = s; total = CW'(tot);
    seen.delete();
    tick(1, 0);
    n = 0;
    while (m_busy && n < 300) begin
      n++;
      if (restart_at > 0 && n == restart_at) begin
        base = 16'hBEEF; total = CW'(2); ctrl = mk_ctrl(0, 1, 0, 0);
        tick(1, 0);
      end else begin
        tick(0, !(stall_mod > 0 && (n % stall_mod) == 0));
      end
    end
    tick(0, 1);
    tick(0, 1);
  endtask

  task automatic expect_seq(string req, logic [15:0] exp[]);
    checks++;
    if (seen.size() != exp.size()) begin
      errors++;
      $display("FAIL %s: beat count %0d expected %0d", req, seen.size(), exp.size());
      return;
    end
    foreach (exp[i]) begin
      checks++;
      if (seen[i] !== exp[i]) begin
        errors++;
        $display("FAIL %s: beat %0d addr %h expected %h", req, i, seen[i], exp[i]);
      end
    end
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R2 reset state: nothing presented
    cur_req = "R2";
    tick(0, 1);

    // R3 increment, 4-byte beats
    run("R3", 16'h0100, mk_ctrl(2, 0, 0, 0), 0, 16, 0, 0);
    expect_seq("R3", '{16'h0100, 16'h0104, 16'h0108, 16'h010C});
    // R1 every size code with increment
    run("R1", 16'h0040, mk_ctrl(0, 0, 0, 0), 0, 3, 0, 0);
    run("R1", 16'h0040, mk_ctrl(1, 0, 0, 0), 0, 6, 0, 0);
    run("R1", 16'h0040, mk_ctrl(3, 0, 0, 0), 0, 24, 0, 0);
    // R4 decrement wrapping through zero
    run("R4", 16'h0004, mk_ctrl(1, 1, 0, 0), 0, 8, 0, 0);
    expect_seq("R4", '{16'h0004, 16'h0002, 16'h0000, 16'hFFFE});
    // R5 static
    run("R5", 16'h3000, mk_ctrl(0, 2, 0, 0), 0, 3, 0, 0);
    expect_seq("R5", '{16'h3000, 16'h3000, 16'h3000});
    // R6 wrapping burst
    run("R6", 16'h1008, mk_ctrl(2, 3, 0, 0), 0, 24, 0, 0);
    expect_seq("R6", '{16'h1008, 16'h100C, 16'h1000, 16'h1004, 16'h1008, 16'h100C});
    // R7 stride with increment
    run("R7", 16'h0200, mk_ctrl(0, 0, 2, 16'h10), 1, 6, 0, 0);
    expect_seq("R7", '{16'h0200, 16'h0201, 16'h0210, 16'h0211, 16'h0220, 16'h0221});
    // R7 stride with decrement and static, stride wrapping the bus
    run("R7", 16'hFFF0, mk_ctrl(1, 1, 4, 16'h20), 1, 10, 0, 0);
    run("R7", 16'h0500, mk_ctrl(2, 2, 8, 16'h100), 1, 20, 3, 0);
    // R8 stride disabled with block size set, and enabled with block size zero
    run("R8", 16'h0700, mk_ctrl(0, 0, 2, 16'h40), 0, 4, 0, 0);
    expect_seq("R8", '{16'h0700, 16'h0701, 16'h0702, 16'h0703});
    run("R8", 16'h0700, mk_ctrl(1, 0, 0, 16'h40), 1, 6, 0, 0);
    // R9 count not a multiple of beat size
    run("R9", 16'h0080, mk_ctrl(2, 0, 0, 0), 0, 6, 0, 0);
    expect_seq("R9", '{16'h0080, 16'h0084});
    // R10 stalls in every other cycle
    run("R10", 16'h0900, mk_ctrl(1, 3, 0, 0), 0, 16, 2, 0);
    // R2 start while busy is ignored
    run("R2", 16'h0A00, mk_ctrl(0, 0, 0, 0), 0, 5, 0, 2);
    expect_seq("R2", '{16'h0A00, 16'h0A01, 16'h0A02, 16'h0A03, 16'h0A04});
    // R11 zero total: done pulse, no beats
    run("R11", 16'h0B00, mk_ctrl(0, 0, 0, 0), 0, 0, 0, 0);
    expect_seq("R11", '{});
    // R11 back-to-back runs with stride and stalls
    run("R11", 16'h0C00, mk_ctrl(1, 0, 6, 16'h8), 1, 14, 4, 0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule